// File: doc/BRIEF.md
# Miss Issue Arbiter

This block decides which outstanding cache-miss entry sends the next acquire request to the next-level cache. It serves two pools of entries. One holds up to four demand-fetch misses and the other up to ten prefetch misses. Each entry raises its own "needs issue" mark. The arbiter keeps these marks internally. A fetch entry is marked through a one-hot set pulse. A prefetch entry is marked through an enqueue stream, which also records arrival order.

When the next-level bus reports idle and no acquire is outstanding, the arbiter picks one entry and launches an acquire on the following clock edge. Fetch entries always beat prefetch entries, and among fetch entries the lowest index wins. Prefetch entries are issued strictly in the order they were enqueued; a small internal order FIFO tracks that order. The acquire is held until the next level accepts it. On acceptance the winning entry's mark is cleared, and a prefetch winner is popped from the order FIFO. The transaction ID places fetch entries on IDs 0 to 3 and prefetch entries on IDs 4 to 13.

Top module: `miss_issue_arb`

## Requirements
- R1: After reset `acq_valid` is 0 and no entry is marked, so no acquire appears until an entry is set or enqueued.
- R2: A new acquire is launched only from a clock edge at which `bus_idle` is 1 and no acquire is outstanding; `acq_valid` rises at that edge, one cycle after the idle cycle is seen.
- R3: While any fetch entry is marked, no prefetch entry is granted.
- R4: Among marked fetch entries, the one with the lowest index is granted first.
- R5: Prefetch entries are granted in the order of their enqueue pulses (`pf_enq_valid` with `pf_enq_idx`).
- R6: While `acq_valid` is 1 and `acq_ready` is 0, `acq_valid`, `acq_id`, `grant_pool` and `grant_idx` stay unchanged, even if `bus_idle` drops.
- R7: `grant_pool` is 0 for a fetch entry and 1 for a prefetch entry; `acq_id` equals `grant_idx` for fetch and 4 + `grant_idx` for prefetch.
- R8: An entry whose acquire was accepted (`acq_valid` and `acq_ready` both 1 at an edge) is not granted again unless it is set or enqueued again.
- R9: An enqueue of a prefetch entry that is already marked is ignored; it neither adds a second grant nor changes the order.
- R10: The order FIFO holds all ten prefetch entries at once, and all of them are then issued exactly once each, in order.
- R11: A prefetch enqueue of the entry whose acquire is accepted in that same cycle is taken as a fresh request, and that entry is granted once more later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_set | input | 4 | One-hot-per-bit pulses marking fetch entries as needing issue |
| pf_enq_valid | input | 1 | Prefetch enqueue pulse |
| pf_enq_idx | input | 4 | Prefetch entry index (0 to 9) being enqueued |
| bus_idle | input | 1 | Next-level request bus is idle |
| acq_valid | output | 1 | Acquire request valid |
| acq_ready | input | 1 | Next level accepts the acquire |
| acq_id | output | 4 | Transaction ID of the acquire |
| grant_pool | output | 1 | Pool of the granted entry (0 fetch, 1 prefetch) |
| grant_idx | output | 4 | Index of the granted entry within its pool |

## Verification
The two functions that can fall into one cycle are the acceptance of a prefetch acquire and a new enqueue of that same prefetch entry. In that cycle the order FIFO pops and pushes, and the entry's mark is cleared and set again. The bench provokes this by raising `acq_ready` and `pf_enq_valid` with the granted index on the same edge. It judges the outcome by requiring exactly one further grant of that entry, followed by silence. A second overlap is a duplicate enqueue of a waiting entry. Here the bench requires that the grant order at the ports is unchanged and that no extra acquire appears.

// File: rtl/miss_arb_pkg.sv
package miss_arb_pkg;

  typedef enum logic {
    POOL_FETCH = 1'b0,
    POOL_PREF  = 1'b1
  } pool_e;

  // width of an index able to address n entries
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/miss_pend_flags.sv
module miss_pend_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  // one flag per entry; a set in the same cycle as a clear wins
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end

endmodule

// File: rtl/miss_low_picker.sv
module miss_low_picker #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/miss_order_fifo.sv
module miss_order_fifo #(
  parameter int DEPTH = 10,
  parameter int W     = 4,
  localparam int PTRW = miss_arb_pkg::idx_w(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         nonempty_o,
  output logic [W-1:0] head_o
);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PTRW-1:0] wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PTRW-1:0] ptr_next(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (pop_i)  rd_q <= ptr_next(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nonempty_o = (cnt_q != '0);
  assign head_o     = mem_q[rd_q];

  // a net push into a full FIFO must never occur (depth equals entry count)
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (cnt_q < CNTW'(DEPTH)));

  // popping is only legal with an entry at the head
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/miss_issue_arb.sv
module miss_issue_arb #(
  parameter int NF = 4,
  parameter int NP = 10,
  localparam int FW  = miss_arb_pkg::idx_w(NF),
  localparam int PW  = miss_arb_pkg::idx_w(NP),
  localparam int IXW = miss_arb_pkg::max_i(FW, PW),
  localparam int IDW = miss_arb_pkg::idx_w(NF + NP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NF-1:0]  fetch_set,
  input  logic           pf_enq_valid,
  input  logic [PW-1:0]  pf_enq_idx,
  input  logic           bus_idle,
  output logic           acq_valid,
  input  logic           acq_ready,
  output logic [IDW-1:0] acq_id,
  output logic           grant_pool,
  output logic [IXW-1:0] grant_idx
);

  import miss_arb_pkg::*;

  function automatic logic [IDW-1:0] form_id(input logic pool, input logic [IXW-1:0] idx);
    return pool ? (IDW'(NF) + IDW'(idx)) : IDW'(idx);
  endfunction

  // ---- handshake events (named for the assertions) ----
  logic hs_fire, fetch_done, pf_done;
  assign hs_fire    = acq_valid & acq_ready;
  assign fetch_done = hs_fire & (grant_pool == POOL_FETCH);
  assign pf_done    = hs_fire & (grant_pool == POOL_PREF);

  // ---- fetch pool ----
  logic [NF-1:0] fetch_pend, fetch_clr;
  logic          f_any;
  logic [FW-1:0] f_idx;

  assign fetch_clr = fetch_done ? (NF'(1) << grant_idx) : '0;

  miss_pend_flags #(.N(NF)) u_fetch_flags (
    .clk(clk), .rst_n(rst_n), .set_i(fetch_set), .clr_i(fetch_clr), .pend_o(fetch_pend)
  );

  miss_low_picker #(.N(NF), .W(FW)) u_fetch_pick (
    .req_i(fetch_pend), .any_o(f_any), .idx_o(f_idx)
  );

  // ---- prefetch pool ----
  logic [NP-1:0] pf_pend, pf_set, pf_clr;
  logic          enq_in_range, pf_same_as_done, pf_dup, pf_push;
  logic          pf_any;
  logic [PW-1:0] pf_head;

  assign enq_in_range    = pf_enq_valid & (pf_enq_idx < PW'(NP));
  assign pf_same_as_done = pf_done & (grant_idx == IXW'(pf_enq_idx));
  assign pf_dup          = enq_in_range & pf_pend[pf_enq_idx] & ~pf_same_as_done;
  assign pf_push         = enq_in_range & ~pf_dup;
  assign pf_set          = pf_push ? (NP'(1) << pf_enq_idx) : '0;
  assign pf_clr          = pf_done ? (NP'(1) << grant_idx) : '0;

  miss_pend_flags #(.N(NP)) u_pf_flags (
    .clk(clk), .rst_n(rst_n), .set_i(pf_set), .clr_i(pf_clr), .pend_o(pf_pend)
  );

  miss_order_fifo #(.DEPTH(NP), .W(PW)) u_pf_order (
    .clk(clk), .rst_n(rst_n),
    .push_i(pf_push), .push_data_i(pf_enq_idx),
    .pop_i(pf_done),
    .nonempty_o(pf_any), .head_o(pf_head)
  );

  // ---- selection ----
  logic           launch, sel_pool;
  logic [IXW-1:0] sel_idx;

  assign launch   = ~acq_valid & bus_idle & (f_any | pf_any);
  assign sel_pool = f_any ? POOL_FETCH : POOL_PREF;
  assign sel_idx  = f_any ? IXW'(f_idx) : IXW'(pf_head);

  // ---- acquire stage, held until accepted ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_valid  <= 1'b0;
      acq_id     <= '0;
      grant_pool <= POOL_FETCH;
      grant_idx  <= '0;
    end else if (launch) begin
      acq_valid  <= 1'b1;
      acq_id     <= form_id(sel_pool, sel_idx);
      grant_pool <= sel_pool;
      grant_idx  <= sel_idx;
    end else if (hs_fire) begin
      acq_valid  <= 1'b0;
    end
  end

  // ---- assertions ----
  logic [NF-1:0] lower_mask;
  assign lower_mask = (NF'(1) << grant_idx) - NF'(1);

  assert_launch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_valid) |-> $past(bus_idle));

  assert_fetch_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acq_valid) && grant_pool) |-> ($past(fetch_pend) == '0));

  assert_lowest_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acq_valid) && !grant_pool) |-> (($past(fetch_pend) & lower_mask) == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && !acq_ready) |=> (acq_valid && $stable(acq_id) && $stable(grant_idx)
                                   && $stable(grant_pool)));

  assert_granted_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_valid) |-> (grant_pool ? pf_pend[grant_idx] : fetch_pend[grant_idx]));

endmodule

// File: tb/tb_miss_issue_arb.sv
module tb_miss_issue_arb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] fetch_set;
  logic       pf_enq_valid;
  logic [3:0] pf_enq_idx;
  logic       bus_idle;
  logic       acq_valid;
  logic       acq_ready;
  logic [3:0] acq_id;
  logic       grant_pool;
  logic [3:0] grant_idx;

  int n_cmp  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  miss_issue_arb dut (
    .clk(clk), .rst_n(rst_n), .fetch_set(fetch_set),
    .pf_enq_valid(pf_enq_valid), .pf_enq_idx(pf_enq_idx), .bus_idle(bus_idle),
    .acq_valid(acq_valid), .acq_ready(acq_ready), .acq_id(acq_id),
    .grant_pool(grant_pool), .grant_idx(grant_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_fetch(input logic [3:0] m);
    fetch_set = m;
    @(negedge clk);
    fetch_set = '0;
  endtask

  task automatic enq_pf(input int idx);
    pf_enq_valid = 1'b1;
    pf_enq_idx   = 4'(idx);
    @(negedge clk);
    pf_enq_valid = 1'b0;
  endtask

  task automatic wait_valid();
    for (int w = 0; w < 30 && !acq_valid; w++) @(negedge clk);
  endtask

  // wait for a grant, check its ID and pool/index split (R7), accept it
  task automatic issue_expect(input int exp_id, input string tag);
    int ep, ei;
    ep = (exp_id >= 4) ? 1 : 0;
    ei = ep ? exp_id - 4 : exp_id;
    wait_valid();
    check(acq_valid == 1'b1, {tag, " valid"}, int'(acq_valid), 1);
    check(int'(acq_id) == exp_id, {tag, " id"}, int'(acq_id), exp_id);
    check(int'(grant_pool) == ep, {tag, " R7 pool"}, int'(grant_pool), ep);
    check(int'(grant_idx) == ei, {tag, " R7 idx"}, int'(grant_idx), ei);
    acq_ready = 1'b1;
    @(negedge clk);
    acq_ready = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (acq_valid) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset();
    check(acq_valid == 1'b0, "R1 valid in reset", int'(acq_valid), 0);
    @(negedge clk);
    rst_n    = 1'b1;
    bus_idle = 1'b1;
    expect_quiet(5, "R1 no acquire after reset");
  endtask

  task automatic t_idle_gate();
    bus_idle = 1'b0;
    pulse_fetch(4'b0100);
    expect_quiet(5, "R2 blocked while busy");
    bus_idle = 1'b1;
    @(negedge clk);
    check(acq_valid == 1'b1, "R2 launch one cycle after idle", int'(acq_valid), 1);
    issue_expect(2, "R2 fetch 2");
  endtask

  task automatic t_priority();
    bus_idle = 1'b0;
    enq_pf(5);
    enq_pf(3);
    pulse_fetch(4'b1010);
    bus_idle = 1'b1;
    issue_expect(1, "R4 lowest fetch");
    issue_expect(3, "R3 fetch before prefetch");
    issue_expect(9, "R5 first prefetch");
    issue_expect(7, "R5 second prefetch");
    expect_quiet(6, "R8 nothing left");
  endtask

  task automatic t_hold();
    logic [3:0] id0;
    pulse_fetch(4'b0001);
    wait_valid();
    id0 = acq_id;
    bus_idle = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(acq_valid && acq_id == id0, "R6 held while not ready", int'(acq_id), int'(id0));
    end
    bus_idle = 1'b1;
    issue_expect(0, "R6 accepted fetch 0");
    expect_quiet(6, "R8 no second grant");
  endtask

  task automatic t_duplicate();
    bus_idle = 1'b0;
    enq_pf(2);
    enq_pf(7);
    enq_pf(2);
    bus_idle = 1'b1;
    issue_expect(6, "R9 order kept first");
    issue_expect(11, "R9 order kept second");
    expect_quiet(6, "R9 duplicate dropped");
  endtask

  task automatic t_rearm();
    enq_pf(4);
    wait_valid();
    check(int'(acq_id) == 8, "R11 first grant id", int'(acq_id), 8);
    acq_ready    = 1'b1;
    pf_enq_valid = 1'b1;
    pf_enq_idx   = 4'd4;
    @(negedge clk);
    acq_ready    = 1'b0;
    pf_enq_valid = 1'b0;
    issue_expect(8, "R11 re-armed grant");
    expect_quiet(6, "R11 only once more");
  endtask

  task automatic t_full();
    bus_idle = 1'b0;
    for (int i = 9; i >= 0; i--) enq_pf(i);
    bus_idle = 1'b1;
    for (int k = 0; k < 10; k++) issue_expect(13 - k, "R10 full order");
    expect_quiet(6, "R10 each exactly once");
  endtask

  initial begin
    rst_n        = 1'b0;
    fetch_set    = '0;
    pf_enq_valid = 1'b0;
    pf_enq_idx   = '0;
    bus_idle     = 1'b0;
    acq_ready    = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle_gate();
    t_priority();
    t_hold();
    t_duplicate();
    t_rearm();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule